// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This controller sits beside the execute stage of a small 16-bit processor. At an instruction boundary it can accept one of three requests: an internal exception, a return-from-interrupt command, or an external device interrupt. On entry it moves the processor into privileged mode. If the processor was running in user mode, it exchanges the stack pointer R6 with a supervisor shadow. It then pushes the old status word and the old program counter onto the supervisor stack, reads the handler address from a vector table and loads it into PC. The return command undoes these steps: it pops PC and then the status word, and it exchanges the stack pointers again when the restored status selects user mode.

The architectural PSR, PC and R6 registers stay in the processor. The sequencer reads them on `psr_in`, `pc_in` and `r6_in`, and changes them through write-enable and write-data pairs. The processor must apply a write on the same clock edge, so the value is visible on the next cycle. Memory is a single-cycle port with an asynchronous read.

The PSR layout is fixed:

| Bits | Meaning |
|------|---------|
| 15 | Privilege: 1 = user, 0 = supervisor |
| 10:8 | Priority level, 7 is the highest |
| 2:0 | Condition codes N, Z, P |

The controller has these states:

| State | Action |
|-------|--------|
| IDLE | Waits for a request at an instruction boundary |
| ENT_SWAP | Clears the privilege bit; if the old mode was user, exchanges the stack pointers |
| ENT_PSR | Pushes the old PSR |
| ENT_PC | Pushes the old PC |
| ENT_VEC | Reads the vector table, loads PC and writes the new PSR |
| RET_PC | Pops PC |
| RET_PSR | Pops the PSR |
| RET_SWAP | Exchanges the stack pointers if the restored mode is user |

The transitions are:
- IDLE goes to ENT_SWAP when an exception or an interrupt is accepted.
- IDLE goes to RET_PC when a return is accepted.
- The entry path runs ENT_SWAP, ENT_PSR, ENT_PC, ENT_VEC and then returns to IDLE.
- The return path runs RET_PC, RET_PSR, RET_SWAP and then returns to IDLE.

Each of these transitions is unconditional except the ones that leave IDLE.

Top module: `intr_seq`

## Requirements
- R1: After reset, the following outputs are low: `busy`, `irq_ack`, `mem_en`, `mem_we`, `psr_we`, `pc_we` and `r6_we`. The supervisor shadow holds `SSP_RESET` (default 0x0800) and the user shadow holds `USP_RESET`.
- R2: A request is accepted only in a cycle where `insn_done` is high and `busy` is low. In any other cycle a request changes no register and starts no sequence.
- R3: An interrupt is accepted only if `irq_prio` is strictly greater than PSR[10:8]. A request at an equal or lower priority is ignored. `irq_ack` is high exactly in the cycle in which the interrupt is accepted.
- R4: When several requests are present at the same boundary, an exception wins over a return, and a return wins over an interrupt. A losing interrupt receives no `irq_ack`.
- R5: An entry from user mode (PSR[15]=1) performs these steps:
  - it copies R6 into the user shadow;
  - it loads the supervisor shadow into R6;
  - it clears PSR[15].
- R6: An entry from supervisor mode leaves both shadows unchanged and uses R6 as it is.
- R7: An entry writes the old PSR at SP-1 and then the old PC at SP-2, where SP is the supervisor stack pointer. R6 ends at SP-2. `busy` is high for exactly 4 cycles.
- R8: The handler address is read from a vector table:
  - an interrupt vector v reads address 0x0180+v;
  - an exception vector v reads address 0x0100+v;
  - v is 7 bits wide in both cases.

  PC takes the word read. PSR[2:0] and PSR[15] become 0. PSR[10:8] takes `irq_prio` for an interrupt and is left unchanged for an exception.
- R9: A return performs these steps:
  - it reads PC from R6;
  - it reads PSR from R6+1;
  - it leaves R6 at R6+2, unless R10 applies.

  `busy` is high for exactly 3 cycles.
- R10: If the popped PSR has bit 15 set, the return copies R6 into the supervisor shadow and loads the user shadow into R6.
- R11: A return request made while PSR[15]=1 pops nothing. It is handled as an exception entry with vector 0x00, which reads address 0x0100.
- R12: `busy` is high from the cycle after acceptance until the sequence ends. Memory writes happen only while `busy` is high, and consecutive pushes go to descending addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | The current instruction has completed; this is a boundary |
| irq_req | input | 1 | Device interrupt request |
| irq_prio | input | 3 | Priority of the requesting device |
| irq_vec | input | 7 | Vector number supplied by the device |
| irq_ack | output | 1 | Interrupt accepted in this cycle |
| exc_req | input | 1 | Internal exception request |
| exc_vec | input | 7 | Exception vector number |
| rti_req | input | 1 | Return-from-interrupt command |
| psr_in | input | 16 | Current PSR |
| pc_in | input | 16 | Current PC |
| r6_in | input | 16 | Current stack pointer R6 |
| psr_we | output | 1 | PSR write enable |
| psr_wd | output | 16 | PSR write data |
| pc_we | output | 1 | PC write enable |
| pc_wd | output | 16 | PC write data |
| r6_we | output | 1 | R6 write enable |
| r6_wd | output | 16 | R6 write data |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write (high) or read (low) |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle |
| busy | output | 1 | A sequence is running; the processor stalls fetch |

## Verification
The hardest situations to reach are the ones whose effect can be seen only through a later sequence:
- the contents of the two stack-pointer shadows;
- a return command issued in user mode.

The stimulus reaches the first by entering from user mode, nesting a higher-priority interrupt, and unwinding both levels back to user mode. The return that restores user mode leaves the supervisor stack pointer in the shadow. A return command issued while still in user mode then raises the privilege exception. That exception must push onto exactly the stack address left in the shadow, which makes the shadow contents visible in the memory writes.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    localparam int PRIV_BIT = 15;
    localparam int PRIO_LSB = 8;
    localparam int CC_W     = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ENT_SWAP,
        S_ENT_PSR,
        S_ENT_PC,
        S_ENT_VEC,
        S_RET_PC,
        S_RET_PSR,
        S_RET_SWAP
    } seq_state_e;

    typedef enum logic [1:0] {
        K_NONE,
        K_EXC,
        K_RTI,
        K_IRQ
    } take_kind_e;

endpackage

// File: rtl/intr_seq_arb.sv
module intr_seq_arb
    import intr_seq_pkg::*;
#(
    parameter int DW      = 16,
    parameter int VEC_W   = 7,
    parameter int PRIO_W  = 3,
    parameter logic [VEC_W-1:0] PRIV_VEC = '0
) (
    input  logic              idle,
    input  logic              insn_done,
    input  logic              exc_req,
    input  logic [VEC_W-1:0]  exc_vec,
    input  logic              rti_req,
    input  logic              irq_req,
    input  logic [PRIO_W-1:0] irq_prio,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic [DW-1:0]     psr_in,
    output take_kind_e        kind,
    output logic              sel_irq,
    output logic [VEC_W-1:0]  sel_vec,
    output logic [PRIO_W-1:0] sel_prio,
    output logic              irq_ack
);

    logic [PRIO_W-1:0] cur_prio;
    logic              boundary;

    assign cur_prio = psr_in[PRIO_LSB +: PRIO_W];
    assign boundary = idle && insn_done;

    always_comb begin
        kind     = K_NONE;
        sel_irq  = 1'b0;
        sel_vec  = exc_vec;
        sel_prio = cur_prio;
        if (boundary) begin
            if (exc_req) begin
                kind = K_EXC;
            end else if (rti_req) begin
                if (psr_in[PRIV_BIT]) begin
                    kind    = K_EXC;
                    sel_vec = PRIV_VEC;
                end else begin
                    kind = K_RTI;
                end
            end else if (irq_req && (irq_prio > cur_prio)) begin
                kind     = K_IRQ;
                sel_irq  = 1'b1;
                sel_vec  = irq_vec;
                sel_prio = irq_prio;
            end
        end
    end

    assign irq_ack = (kind == K_IRQ);

endmodule

// File: rtl/intr_seq_spbank.sv
module intr_seq_spbank #(
    parameter int            DW        = 16,
    parameter logic [DW-1:0] SSP_RESET = 16'h0800,
    parameter logic [DW-1:0] USP_RESET = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_usp,
    input  logic          save_ssp,
    input  logic [DW-1:0] sp_din,
    output logic [DW-1:0] usp_q,
    output logic [DW-1:0] ssp_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            usp_q <= USP_RESET;
            ssp_q <= SSP_RESET;
        end else begin
            if (save_usp) usp_q <= sp_din;
            if (save_ssp) ssp_q <= sp_din;
        end
    end

    // R10
    shadow_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_usp |-> !save_ssp);

endmodule

// File: rtl/intr_seq_fsm.sv
module intr_seq_fsm
    import intr_seq_pkg::*;
#(
    parameter int DW     = 16,
    parameter int VEC_W  = 7,
    parameter int PRIO_W = 3,
    parameter logic [DW-VEC_W-2:0] TABLE_PAGE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  take_kind_e        kind,
    input  logic              sel_irq,
    input  logic [VEC_W-1:0]  sel_vec,
    input  logic [PRIO_W-1:0] sel_prio,
    input  logic [DW-1:0]     psr_in,
    input  logic [DW-1:0]     pc_in,
    input  logic [DW-1:0]     r6_in,
    input  logic [DW-1:0]     mem_rdata,
    input  logic [DW-1:0]     usp_q,
    input  logic [DW-1:0]     ssp_q,
    output logic              idle,
    output logic              busy,
    output logic              psr_we,
    output logic [DW-1:0]     psr_wd,
    output logic              pc_we,
    output logic [DW-1:0]     pc_wd,
    output logic              r6_we,
    output logic [DW-1:0]     r6_wd,
    output logic              mem_en,
    output logic              mem_we,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic              save_usp,
    output logic              save_ssp,
    output logic [DW-1:0]     sp_din
);

    localparam logic [DW-1:0] ONE = DW'(1);

    seq_state_e        state, state_nx;
    logic [DW-1:0]     old_psr;
    logic [DW-1:0]     old_pc;
    logic [DW-1:0]     vec_addr;
    logic [PRIO_W-1:0] new_prio;
    logic              ret_user;
    logic [DW-1:0]     psr_sup;
    logic [DW-1:0]     psr_handler;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (kind == K_EXC || kind == K_IRQ) state_nx = S_ENT_SWAP;
                else if (kind == K_RTI)             state_nx = S_RET_PC;
            end
            S_ENT_SWAP: state_nx = S_ENT_PSR;
            S_ENT_PSR:  state_nx = S_ENT_PC;
            S_ENT_PC:   state_nx = S_ENT_VEC;
            S_ENT_VEC:  state_nx = S_IDLE;
            S_RET_PC:   state_nx = S_RET_PSR;
            S_RET_PSR:  state_nx = S_RET_SWAP;
            S_RET_SWAP: state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            old_psr  <= '0;
            old_pc   <= '0;
            vec_addr <= '0;
            new_prio <= '0;
            ret_user <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && (kind == K_EXC || kind == K_IRQ)) begin
                old_psr  <= psr_in;
                old_pc   <= pc_in;
                vec_addr <= {TABLE_PAGE, sel_irq, sel_vec};
                new_prio <= sel_prio;
            end
            if (state == S_RET_PSR) ret_user <= mem_rdata[PRIV_BIT];
        end
    end

    always_comb begin
        psr_sup = old_psr;
        psr_sup[PRIV_BIT] = 1'b0;
        psr_handler = psr_sup;
        psr_handler[PRIO_LSB +: PRIO_W] = new_prio;
        psr_handler[CC_W-1:0] = '0;
    end

    always_comb begin
        idle      = (state == S_IDLE);
        busy      = !idle;
        psr_we    = 1'b0;
        psr_wd    = '0;
        pc_we     = 1'b0;
        pc_wd     = '0;
        r6_we     = 1'b0;
        r6_wd     = '0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        save_usp  = 1'b0;
        save_ssp  = 1'b0;
        sp_din    = r6_in;
        unique case (state)
            S_IDLE: ;
            S_ENT_SWAP: begin
                psr_we = 1'b1;
                psr_wd = psr_sup;
                if (old_psr[PRIV_BIT]) begin
                    save_usp = 1'b1;
                    r6_we    = 1'b1;
                    r6_wd    = ssp_q;
                end
            end
            S_ENT_PSR, S_ENT_PC: begin
                r6_we     = 1'b1;
                r6_wd     = r6_in - ONE;
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r6_in - ONE;
                mem_wdata = (state == S_ENT_PSR) ? old_psr : old_pc;
            end
            S_ENT_VEC: begin
                mem_en   = 1'b1;
                mem_addr = vec_addr;
                pc_we    = 1'b1;
                pc_wd    = mem_rdata;
                psr_we   = 1'b1;
                psr_wd   = psr_handler;
            end
            S_RET_PC: begin
                mem_en   = 1'b1;
                mem_addr = r6_in;
                pc_we    = 1'b1;
                pc_wd    = mem_rdata;
                r6_we    = 1'b1;
                r6_wd    = r6_in + ONE;
            end
            S_RET_PSR: begin
                mem_en   = 1'b1;
                mem_addr = r6_in;
                psr_we   = 1'b1;
                psr_wd   = mem_rdata;
                r6_we    = 1'b1;
                r6_wd    = r6_in + ONE;
            end
            S_RET_SWAP: begin
                if (ret_user) begin
                    save_ssp = 1'b1;
                    r6_we    = 1'b1;
                    r6_wd    = usp_q;
                end
            end
            default: ;
        endcase
    end

    // R7
    entry_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ENT_PSR) |=> (state == S_ENT_PC) && mem_we);

    // R9
    return_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RET_PC) |=> (state == S_RET_PSR) && psr_we);

endmodule

// File: rtl/intr_seq.sv
module intr_seq
    import intr_seq_pkg::*;
#(
    parameter int DW     = 16,
    parameter int VEC_W  = 7,
    parameter int PRIO_W = 3,
    parameter logic [DW-VEC_W-2:0] TABLE_PAGE = 8'h01,
    parameter logic [VEC_W-1:0]    PRIV_VEC   = 7'h00,
    parameter logic [DW-1:0]       SSP_RESET  = 16'h0800,
    parameter logic [DW-1:0]       USP_RESET  = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_done,
    input  logic              irq_req,
    input  logic [PRIO_W-1:0] irq_prio,
    input  logic [VEC_W-1:0]  irq_vec,
    output logic              irq_ack,
    input  logic              exc_req,
    input  logic [VEC_W-1:0]  exc_vec,
    input  logic              rti_req,
    input  logic [DW-1:0]     psr_in,
    input  logic [DW-1:0]     pc_in,
    input  logic [DW-1:0]     r6_in,
    output logic              psr_we,
    output logic [DW-1:0]     psr_wd,
    output logic              pc_we,
    output logic [DW-1:0]     pc_wd,
    output logic              r6_we,
    output logic [DW-1:0]     r6_wd,
    output logic              mem_en,
    output logic              mem_we,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic              busy
);

    take_kind_e        kind;
    logic              sel_irq;
    logic [VEC_W-1:0]  sel_vec;
    logic [PRIO_W-1:0] sel_prio;
    logic              idle;
    logic              save_usp;
    logic              save_ssp;
    logic [DW-1:0]     sp_din;
    logic [DW-1:0]     usp_q;
    logic [DW-1:0]     ssp_q;

    intr_seq_arb #(
        .DW(DW), .VEC_W(VEC_W), .PRIO_W(PRIO_W), .PRIV_VEC(PRIV_VEC)
    ) u_arb (
        .idle(idle), .insn_done(insn_done),
        .exc_req(exc_req), .exc_vec(exc_vec), .rti_req(rti_req),
        .irq_req(irq_req), .irq_prio(irq_prio), .irq_vec(irq_vec),
        .psr_in(psr_in), .kind(kind), .sel_irq(sel_irq),
        .sel_vec(sel_vec), .sel_prio(sel_prio), .irq_ack(irq_ack)
    );

    intr_seq_spbank #(
        .DW(DW), .SSP_RESET(SSP_RESET), .USP_RESET(USP_RESET)
    ) u_spbank (
        .clk(clk), .rst_n(rst_n), .save_usp(save_usp), .save_ssp(save_ssp),
        .sp_din(sp_din), .usp_q(usp_q), .ssp_q(ssp_q)
    );

    intr_seq_fsm #(
        .DW(DW), .VEC_W(VEC_W), .PRIO_W(PRIO_W), .TABLE_PAGE(TABLE_PAGE)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .kind(kind), .sel_irq(sel_irq),
        .sel_vec(sel_vec), .sel_prio(sel_prio),
        .psr_in(psr_in), .pc_in(pc_in), .r6_in(r6_in),
        .mem_rdata(mem_rdata), .usp_q(usp_q), .ssp_q(ssp_q),
        .idle(idle), .busy(busy),
        .psr_we(psr_we), .psr_wd(psr_wd), .pc_we(pc_we), .pc_wd(pc_wd),
        .r6_we(r6_we), .r6_wd(r6_wd),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata),
        .save_usp(save_usp), .save_ssp(save_ssp), .sp_din(sp_din)
    );

    // R3
    ack_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> busy);

    // R2
    boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(insn_done));

    // R12
    write_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R12
    push_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) - 16'd1);

endmodule

// File: tb/intr_seq_tb.sv
`timescale 1ns/1ps
module intr_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_done = 1'b0;
    logic        irq_req = 1'b0;
    logic [2:0]  irq_prio = '0;
    logic [6:0]  irq_vec = '0;
    logic        irq_ack;
    logic        exc_req = 1'b0;
    logic [6:0]  exc_vec = '0;
    logic        rti_req = 1'b0;
    logic [15:0] psr, pc, r6;
    logic        psr_we, pc_we, r6_we, mem_en, mem_we, busy;
    logic [15:0] psr_wd, pc_wd, r6_wd, mem_addr, mem_wdata, mem_rdata;
    logic [15:0] mem [0:4095];
    logic        poke = 1'b0;
    logic [15:0] poke_psr = '0, poke_pc = '0;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;
    bit exp_busy = 1'b0;

    logic [15:0] m_psr = 16'h8002, m_pc = 16'h3000, m_r6 = 16'h0F00;
    logic [15:0] m_usp = 16'h0000, m_ssp = 16'h0800;
    logic [31:0] wq [$];

    always #2.5 clk = ~clk;

    intr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done),
        .irq_req(irq_req), .irq_prio(irq_prio), .irq_vec(irq_vec),
        .irq_ack(irq_ack), .exc_req(exc_req), .exc_vec(exc_vec),
        .rti_req(rti_req), .psr_in(psr), .pc_in(pc), .r6_in(r6),
        .psr_we(psr_we), .psr_wd(psr_wd), .pc_we(pc_we), .pc_wd(pc_wd),
        .r6_we(r6_we), .r6_wd(r6_wd), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy)
    );

    assign mem_rdata = mem_en ? mem[mem_addr[11:0]] : 16'h0000;

    // processor register file and memory
    always @(posedge clk) begin
        if (!rst_n) begin
            psr <= 16'h8002;
            pc  <= 16'h3000;
            r6  <= 16'h0F00;
            for (int i = 0; i < 256; i++) mem[256 + i] <= 16'h4000 + 16'(i * 16);
        end else if (poke) begin
            psr <= poke_psr;
            pc  <= poke_pc;
        end else begin
            if (psr_we) psr <= psr_wd;
            if (pc_we)  pc  <= pc_wd;
            if (r6_we)  r6  <= r6_wd;
            if (mem_en && mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // per-clock comparison of busy and memory writes against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R12", "busy", {31'd0, busy}, {31'd0, exp_busy});
            if (mem_we) begin
                if (wq.size() == 0) chk("R7", "unexpected write addr", {16'd0, mem_addr}, 32'hFFFF_FFFF);
                else begin
                    logic [31:0] w;
                    w = wq.pop_front();
                    chk("R7", "push addr/data", {mem_addr, mem_wdata}, w);
                end
            end
        end
    end

    task automatic model_entry(input bit is_irq, input logic [6:0] v, input logic [2:0] np);
        logic [15:0] sp, va;
        if (m_psr[15]) begin
            m_usp = m_r6;
            sp = m_ssp;
        end else begin
            sp = m_r6;
        end
        wq.push_back({sp - 16'd1, m_psr});
        wq.push_back({sp - 16'd2, m_pc});
        va = 16'h0100 + (is_irq ? 16'h0080 : 16'h0000) + {9'd0, v};
        m_pc = mem[va[11:0]];
        m_psr = {1'b0, m_psr[14:11], np, m_psr[7:3], 3'b000};
        m_r6 = sp - 16'd2;
    endtask

    task automatic model_return();
        logic [15:0] p, r;
        m_pc = mem[m_r6[11:0]];
        p = mem[(m_r6 + 16'd1) & 16'h0FFF];
        r = m_r6 + 16'd2;
        if (p[15]) begin
            m_ssp = r;
            r = m_usp;
        end
        m_r6 = r;
        m_psr = p;
    endtask

    task automatic clear_inputs();
        insn_done = 0; exc_req = 0; rti_req = 0; irq_req = 0;
    endtask

    task automatic cmp_regs(input string req);
        chk(req, "psr", {16'd0, psr}, {16'd0, m_psr});
        chk(req, "pc",  {16'd0, pc},  {16'd0, m_pc});
        chk(req, "r6",  {16'd0, r6},  {16'd0, m_r6});
    endtask

    task automatic fire(input bit e, input bit r, input bit q, input logic [6:0] v,
                        input logic [2:0] p, input int cycles, input bit exp_ack,
                        input string req);
        @(negedge clk);
        insn_done = 1;
        exc_req = e; rti_req = r; irq_req = q;
        exc_vec = v; irq_vec = v; irq_prio = p;
        #1 chk(req, "irq_ack", {31'd0, irq_ack}, {31'd0, exp_ack});
        @(posedge clk);
        #1 exp_busy = 1'b1;
        clear_inputs();
        repeat (cycles) @(posedge clk);
        #1 exp_busy = 1'b0;
        @(negedge clk);
        cmp_regs(req);
        chk(req, "pending writes", wq.size(), 0);
    endtask

    task automatic ignored(input bit ins, input logic [2:0] p, input int cycles, input string req);
        @(negedge clk);
        insn_done = ins; irq_req = 1; irq_vec = 7'h22; irq_prio = p;
        for (int i = 0; i < cycles; i++) begin
            #1 chk(req, "irq_ack when ignored", {31'd0, irq_ack}, 32'd0);
            @(negedge clk);
        end
        clear_inputs();
        @(negedge clk);
        cmp_regs(req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", {31'd0, busy}, 0);
        chk("R1", "irq_ack", {31'd0, irq_ack}, 0);
        chk("R1", "mem_en/we", {30'd0, mem_en, mem_we}, 0);
        chk("R1", "reg write enables", {29'd0, psr_we, pc_we, r6_we}, 0);
        cmp_regs("R1");
        // R2: high-priority request without an instruction boundary
        ignored(1'b0, 3'd5, 4, "R2");
        // R5 R7 R8 R3: interrupt from user mode, prio 3, vector 0x01
        model_entry(1'b1, 7'h01, 3'd3);
        fire(0, 0, 1, 7'h01, 3'd3, 4, 1'b1, "R5");
        // R3: equal and lower priority ignored
        ignored(1'b1, 3'd3, 3, "R3");
        ignored(1'b1, 3'd2, 3, "R3");
        // R6: nested interrupt from supervisor, no swap
        model_entry(1'b1, 7'h10, 3'd6);
        fire(0, 0, 1, 7'h10, 3'd6, 4, 1'b1, "R6");
        // R9: return to the outer supervisor level
        model_return();
        fire(0, 1, 0, 7'h00, 3'd0, 3, 1'b0, "R9");
        // R10: return to user mode
        model_return();
        fire(0, 1, 0, 7'h00, 3'd0, 3, 1'b0, "R10");
        // R11: return in user mode is a privilege exception, stack from shadow
        model_entry(1'b0, 7'h00, m_psr[10:8]);
        fire(0, 1, 0, 7'h00, 3'd0, 4, 1'b0, "R11");
        model_return();
        fire(0, 1, 0, 7'h00, 3'd0, 3, 1'b0, "R10");
        // R4 R8: exception beats a prio-7 interrupt; priority unchanged
        @(negedge clk);
        poke = 1; poke_psr = 16'h8204; poke_pc = 16'h3100;
        @(negedge clk);
        poke = 0;
        m_psr = 16'h8204; m_pc = 16'h3100;
        model_entry(1'b0, 7'h05, 3'd2);
        fire(1, 0, 1, 7'h05, 3'd7, 4, 1'b0, "R4");
        // R4: return beats a prio-7 interrupt
        model_return();
        fire(0, 1, 1, 7'h00, 3'd7, 3, 1'b0, "R4");
        // R8: highest interrupt vector, address 0x01FF
        model_entry(1'b1, 7'h7F, 3'd7);
        fire(0, 0, 1, 7'h7F, 3'd7, 4, 1'b1, "R8");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule